// File: doc/BRIEF.md
# Coin Vending Controller

This block is a Mealy state machine that sits behind a coin acceptor and decides when to hand out one item and which change to pay back. Each coin comes in as a two-bit code together with a one-cycle valid strobe. The block keeps a running credit of 0, 5, 10 or 15 cents. When a strobed coin brings the credit to 20 cents or more, the block dispenses in that same cycle and pays back change with a nickel return line, a dime return line, or both.

The outputs are combinational functions of the present credit and the strobed coin. They are meaningful only in a cycle where the strobe is high. The credit register moves on the clock edge that ends that cycle. Change is capped at 15 cents. When a quarter arrives on top of 15 cents, the controller dispenses, returns a nickel and a dime, and keeps the leftover 5 cents as credit for the next purchase.

Top module: `coin_vend_top`

## Requirements
- R1: A synchronous active-high reset clears the credit to 0 cents. After reset, the block behaves exactly as a fresh machine, so a dime followed by a dime dispenses on the second dime.
- R2: While `coinValid` is low, all three outputs are 0 and the credit does not change, whatever `coinCode` carries.
- R3: The coin encoding is 2'b00 nickel (5 cents), 2'b01 dime (10 cents) and 2'b10 quarter (25 cents). The outputs respond in the same cycle as the strobed coin.
- R4: A strobed coin that leaves the total below 20 cents raises no output, and the credit becomes the new total.
- R5: A strobed coin that makes the total exactly 20 cents raises `dispense` only, and the credit returns to 0.
- R6: A total of 25 cents dispenses and returns a nickel. A total of 30 cents dispenses and returns a dime. A total of 35 cents dispenses and returns both. In each case the credit returns to 0.
- R7: A quarter inserted at 15 cents dispenses and returns both a nickel and a dime, and the credit becomes 5 cents.
- R8: The code 2'b11 with `coinValid` high drives all outputs to 0 and leaves the credit unchanged.
- R9: `returnNickel` or `returnDime` is high only in a cycle where `dispense` is high.
- R10: A strobed quarter always dispenses, whatever the credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the credit updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coinValid | input | 1 | Strobe; high for one cycle per inserted coin |
| coinCode | input | 2 | Coin type: 00 nickel, 01 dime, 10 quarter, 11 unused |
| dispense | output | 1 | Hand out one item (same cycle as the coin) |
| returnNickel | output | 1 | Pay back a nickel (same cycle as the coin) |
| returnDime | output | 1 | Pay back a dime (same cycle as the coin) |

## Verification
The bench targets the quarter-at-15-cents case. A design that returned to zero there would dispense correctly but would then need 20 more cents on the next purchase instead of 15, so the bench follows the case with a nickel and a dime to expose the lost credit. It drives idle cycles and the unused code 11 at a nonzero credit, then completes a purchase with the exact coins. A design that let either stimulus move the state would dispense one coin early or late. Exact-price totals and every overpay amount are driven separately. A swapped nickel and dime return, or change paid out on an exact 20 cents, shows up directly on the outputs. A reset taken mid-purchase is followed by two dimes, which catches any credit that survives the reset.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Coin codes seen on coinCode
  localparam logic [1:0] COIN_NICKEL = 2'b00;
  localparam logic [1:0] COIN_DIME   = 2'b01;
  localparam logic [1:0] COIN_QUART  = 2'b10;
  localparam logic [1:0] COIN_UNUSED = 2'b11;

  // Coin values in units of 5 cents
  localparam int NICKEL_UNITS = 1;
  localparam int DIME_UNITS   = 2;
  localparam int QUART_UNITS  = 5;

  // Most change the two return chutes can pay at once (nickel + dime)
  localparam int MAX_CHANGE_UNITS = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // accepted coin, total below price: load total
    logic settle;   // accepted coin, total reaches price: sell, pay change
  } vend_strobe_t;

endpackage

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
#(
  parameter int PRICE_UNITS = 4,
  parameter int CREDIT_W    = $clog2(PRICE_UNITS),
  parameter int SUM_W       = $clog2(PRICE_UNITS + QUART_UNITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          coinCode,
  input  vend_strobe_t        strobes,
  output logic                reachPrice,
  output logic [CREDIT_W-1:0] creditLevel,
  output logic                returnNickel,
  output logic                returnDime
);

  logic [CREDIT_W-1:0] creditQ;
  logic [SUM_W-1:0]    coinUnits;
  logic [SUM_W-1:0]    total;
  logic [SUM_W-1:0]    excess;
  logic [1:0]          changeUnits;

  always_comb begin
    case (coinCode)
      COIN_NICKEL: coinUnits = SUM_W'(NICKEL_UNITS);
      COIN_DIME:   coinUnits = SUM_W'(DIME_UNITS);
      COIN_QUART:  coinUnits = SUM_W'(QUART_UNITS);
      default:     coinUnits = '0;
    endcase
  end

  assign total      = SUM_W'(creditQ) + coinUnits;
  assign reachPrice = total >= SUM_W'(PRICE_UNITS);
  assign excess     = total - SUM_W'(PRICE_UNITS);

  // Change capped at what the two chutes can pay; any rest stays as credit
  assign changeUnits = (excess >= SUM_W'(MAX_CHANGE_UNITS)) ? 2'(MAX_CHANGE_UNITS)
                                                            : excess[1:0];

  always_ff @(posedge clk) begin
    if (rst)                  creditQ <= '0;
    else if (strobes.advance) creditQ <= CREDIT_W'(total);
    else if (strobes.settle)  creditQ <= CREDIT_W'(excess - SUM_W'(changeUnits));
  end

  assign creditLevel  = creditQ;
  assign returnNickel = strobes.settle & changeUnits[0];
  assign returnDime   = strobes.settle & changeUnits[1];

endmodule

// File: rtl/vend_control.sv
module vend_control
  import vend_pkg::*;
(
  input  logic         coinValid,
  input  logic [1:0]   coinCode,
  input  logic         reachPrice,
  output vend_strobe_t strobes,
  output logic         dispense
);

  logic accepted;

  assign accepted        = coinValid && (coinCode != COIN_UNUSED);
  assign strobes.advance = accepted && !reachPrice;
  assign strobes.settle  = accepted && reachPrice;
  assign dispense        = strobes.settle;

endmodule

// File: rtl/coin_vend_top.sv
module coin_vend_top
  import vend_pkg::*;
#(
  parameter int PRICE_UNITS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       coinValid,
  input  logic [1:0] coinCode,
  output logic       dispense,
  output logic       returnNickel,
  output logic       returnDime
);

  localparam int CREDIT_W = $clog2(PRICE_UNITS);
  localparam int SUM_W    = $clog2(PRICE_UNITS + QUART_UNITS);

  vend_strobe_t        strobes;
  logic                reachPrice;
  logic [CREDIT_W-1:0] creditLevel;

  vend_control i_control (
    .coinValid (coinValid),
    .coinCode  (coinCode),
    .reachPrice(reachPrice),
    .strobes   (strobes),
    .dispense  (dispense)
  );

  vend_datapath #(
    .PRICE_UNITS(PRICE_UNITS),
    .CREDIT_W   (CREDIT_W),
    .SUM_W      (SUM_W)
  ) i_datapath (
    .clk         (clk),
    .rst         (rst),
    .coinCode    (coinCode),
    .strobes     (strobes),
    .reachPrice  (reachPrice),
    .creditLevel (creditLevel),
    .returnNickel(returnNickel),
    .returnDime  (returnDime)
  );

endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk #(
  parameter int CREDIT_W = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                coinValid,
  input logic [1:0]          coinCode,
  input logic                dispense,
  input logic                returnNickel,
  input logic                returnDime,
  input logic [CREDIT_W-1:0] creditLevel
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> creditLevel == '0);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !coinValid |-> !(dispense || returnNickel || returnDime));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !coinValid |=> $stable(creditLevel));

  assert_nickel_from_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (coinValid && coinCode == 2'b00 && creditLevel == '0) |=> creditLevel == CREDIT_W'(1));

  assert_quarter_at_top_R7: assert property (@(posedge clk) disable iff (rst)
    (coinValid && coinCode == 2'b10 && creditLevel == '1) |=> creditLevel == CREDIT_W'(1));

  assert_unused_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (coinValid && coinCode == 2'b11) |-> !(dispense || returnNickel || returnDime));

  assert_unused_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (coinValid && coinCode == 2'b11) |=> $stable(creditLevel));

  assert_change_needs_sale_R9: assert property (@(posedge clk) disable iff (rst)
    (returnNickel || returnDime) |-> dispense);

  assert_quarter_sells_R10: assert property (@(posedge clk) disable iff (rst)
    (coinValid && coinCode == 2'b10) |-> dispense);

endmodule

bind coin_vend_top coin_vend_chk #(.CREDIT_W(CREDIT_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .coinValid   (coinValid),
  .coinCode    (coinCode),
  .dispense    (dispense),
  .returnNickel(returnNickel),
  .returnDime  (returnDime),
  .creditLevel (creditLevel)
);

// File: tb/test_coin_vend_top.sv
module test_coin_vend_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coinValid = 1'b0;
  logic [1:0] coinCode = 2'b00;
  logic       dispense, returnNickel, returnDime;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;  // 100 MHz

  coin_vend_top i_coin_vend_top (
    .clk         (clk),
    .rst         (rst),
    .coinValid   (coinValid),
    .coinCode    (coinCode),
    .dispense    (dispense),
    .returnNickel(returnNickel),
    .returnDime  (returnDime)
  );

  // Each vector: reset, strobe, code, expected {dispense, nickel, dime}, requirement
  typedef struct packed {
    logic       rstIn;
    logic       vld;
    logic [1:0] code;
    logic [2:0] expOut;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 28;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 2'b00, 3'b000, 4'd4},  // 0 -> 5   R4
    '{1'b0, 1'b1, 2'b00, 3'b000, 4'd4},  // 5 -> 10
    '{1'b0, 1'b1, 2'b00, 3'b000, 4'd4},  // 10 -> 15
    '{1'b0, 1'b1, 2'b00, 3'b100, 4'd5},  // 15+5 = 20 exact R5
    '{1'b0, 1'b1, 2'b01, 3'b000, 4'd4},  // 0 -> 10
    '{1'b0, 1'b1, 2'b01, 3'b100, 4'd5},  // 10+10 exact R5
    '{1'b0, 1'b1, 2'b10, 3'b110, 4'd6},  // 0+25 -> nickel R6
    '{1'b0, 1'b1, 2'b00, 3'b000, 4'd4},  // 0 -> 5
    '{1'b0, 1'b1, 2'b10, 3'b101, 4'd6},  // 5+25 -> dime R6
    '{1'b0, 1'b1, 2'b01, 3'b000, 4'd4},  // 0 -> 10
    '{1'b0, 1'b1, 2'b10, 3'b111, 4'd6},  // 10+25 -> both R6
    '{1'b0, 1'b1, 2'b00, 3'b000, 4'd4},  // 0 -> 5
    '{1'b0, 1'b1, 2'b01, 3'b000, 4'd4},  // 5 -> 15
    '{1'b0, 1'b0, 2'b10, 3'b000, 4'd2},  // idle quarter on bus R2
    '{1'b0, 1'b0, 2'b01, 3'b000, 4'd2},  // idle dime on bus R2
    '{1'b0, 1'b1, 2'b11, 3'b000, 4'd8},  // unused code at 15 R8
    '{1'b0, 1'b1, 2'b10, 3'b111, 4'd7},  // 15+25 -> both, keep 5 R7
    '{1'b0, 1'b1, 2'b00, 3'b000, 4'd7},  // 5 -> 10 proves kept credit R7
    '{1'b0, 1'b1, 2'b01, 3'b100, 4'd5},  // 10+10 exact
    '{1'b0, 1'b1, 2'b01, 3'b000, 4'd4},  // 0 -> 10
    '{1'b0, 1'b1, 2'b00, 3'b000, 4'd4},  // 10 -> 15
    '{1'b0, 1'b1, 2'b01, 3'b110, 4'd6},  // 15+10 = 25 -> nickel R6
    '{1'b0, 1'b1, 2'b11, 3'b000, 4'd8},  // unused code at 0 R8
    '{1'b0, 1'b1, 2'b00, 3'b000, 4'd8},  // 0 -> 5 proves 11 did nothing
    '{1'b0, 1'b1, 2'b01, 3'b000, 4'd4},  // 5 -> 15
    '{1'b1, 1'b0, 2'b00, 3'b000, 4'd1},  // reset mid purchase R1
    '{1'b0, 1'b1, 2'b01, 3'b000, 4'd1},  // 0 -> 10 after reset R1
    '{1'b0, 1'b1, 2'b01, 3'b100, 4'd1}   // 10+10 sells R1
  };

  task automatic check_out(input logic [2:0] expOut, input int req, input string what);
    logic [2:0] got;
    got = {dispense, returnNickel, returnDime};
    checks++;
    if (got !== expOut) begin
      fails++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, got, expOut);
    end
  endtask

  task automatic apply(input logic r, input logic v, input logic [1:0] c,
                       input logic [2:0] expOut, input int req, input string what);
    @(negedge clk);
    rst = r; coinValid = v; coinCode = c;
    #1;
    if (!r) check_out(expOut, req, what);
  endtask

  initial begin
    rst = 1'b1; coinValid = 1'b0;
    repeat (3) @(posedge clk);
    // Reset state: quiet outputs, credit 0 so a quarter pays a nickel (R1, R3)
    apply(1'b0, 1'b0, 2'b00, 3'b000, 1, "reset state idle");
    apply(1'b0, 1'b1, 2'b10, 3'b110, 3, "quarter code after reset");

    for (int i = 0; i < NVEC; i++)
      apply(VECS[i].rstIn, VECS[i].vld, VECS[i].code, VECS[i].expOut,
            int'(VECS[i].req), $sformatf("vector %0d", i));

    // Long idle at 10 cents must keep the credit (R2)
    apply(1'b0, 1'b1, 2'b01, 3'b000, 4, "load 10");
    for (int k = 0; k < 20; k++)
      apply(1'b0, 1'b0, 2'(k), 3'b000, 2, "long idle");
    apply(1'b0, 1'b1, 2'b01, 3'b100, 2, "10 kept after idle");

    // Quarter sells from every credit level (R10, R9)
    apply(1'b0, 1'b1, 2'b10, 3'b110, 10, "quarter at 0");
    apply(1'b0, 1'b1, 2'b00, 3'b000, 4, "to 5");
    apply(1'b0, 1'b1, 2'b10, 3'b101, 10, "quarter at 5");
    apply(1'b0, 1'b1, 2'b00, 3'b000, 4, "to 5");
    apply(1'b0, 1'b1, 2'b00, 3'b000, 4, "to 10");
    apply(1'b0, 1'b1, 2'b10, 3'b111, 9, "quarter at 10");
    apply(1'b0, 1'b1, 2'b01, 3'b000, 4, "to 10");
    apply(1'b0, 1'b1, 2'b00, 3'b000, 4, "to 15");
    apply(1'b0, 1'b1, 2'b10, 3'b111, 7, "quarter at 15");
    apply(1'b0, 1'b1, 2'b00, 3'b000, 7, "5 kept -> 10");
    apply(1'b0, 1'b1, 2'b00, 3'b000, 7, "-> 15");
    apply(1'b0, 1'b1, 2'b00, 3'b100, 7, "15+5 exact");

    @(negedge clk);
    coinValid = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule